// File: doc/BRIEF.md
# Compare-Driven Pulse and PWM Generator

This block is a 16-bit up-counting timer with two compare values and one waveform output. It has two modes. In continuous mode it produces a pulse-width-modulated wave. The first compare value sets how long the pulse lasts, and the second sets the period. In single-shot mode it sits idle until a trigger edge arrives, then produces one pulse whose length is set by the first compare value, and then goes back to waiting.

The counter always starts a period at 0xFFFC, not at zero. Two level inputs choose the output value during the pulse and after it, so the polarity is programmable. The counter advances on a tick. The tick comes either from the system clock through an 8-bit prescaler or from an external clock pin that passes through a synchronizer. Four sticky event flags report compare matches, counter wrap and accepted triggers. Each flag is cleared by writing a one to it.

The control logic is one state machine with four states.
- STOP: the block is disabled.
- WAIT: single-shot mode, waiting for a trigger.
- PULSE: the output is at the pulse level.
- AFTER: continuous mode, the pulse has ended and the period has not.

The transitions are:
- STOP→PULSE when enabled in continuous mode.
- STOP→WAIT when enabled in single-shot mode.
- WAIT→PULSE on an accepted trigger.
- PULSE→AFTER on a compare-1 match in continuous mode.
- PULSE→WAIT on a compare-1 match in single-shot mode.
- PULSE→PULSE and AFTER→PULSE on a compare-2 reload.
- any state→STOP when the enable input goes low.

Top module: `pwmgen_top`

## Requirements
- R1: During and after reset, with the block disabled, wave_out equals lvl_idle, flags is 0 and cnt_out is 0xFFFC.
- R2: Continuous mode is mode=0. On the enabling clock edge the state becomes PULSE with the counter at 0xFFFC. Each tick on which the counter equals cmp1 ends the pulse, so wave_out = lvl_pulse for cmp1+5 ticks (mod 2^16). A tick on which the counter equals cmp2 reloads the counter to 0xFFFC and starts a new pulse, so the period is cmp2+5 ticks (mod 2^16).
- R3: In continuous mode, if the counter reaches cmp2 before cmp1 within a period, the reload takes priority and wave_out stays at lvl_pulse.
- R4: Single-shot mode is mode=1.
  - While waiting, the counter holds 0xFFFC and wave_out = lvl_idle.
  - A trigger edge starts the pulse: a rising edge when trig_rise=1, a falling edge when trig_rise=0. wave_out becomes lvl_pulse after the third clock edge that follows the pin change.
  - The pulse lasts cmp1+5 ticks. The counter then returns to 0xFFFC and the block waits again.
- R5: Trigger edges that are detected during an active single-shot pulse are ignored. They do not stretch or restart the pulse, and no pulse follows them.
- R6: With clk_sel=0 and presc=p, ticks fall on clock edges j*(p+1)+p, for j ≥ 0, counting the enabling edge as edge 0.
- R7: With clk_sel=1, presc is ignored. Each rising edge of ext_clk, with each level held at least two clocks, advances the counter exactly once.
- R8: Flag bit 2 is set when the counter steps from 0xFFFF to 0x0000. A reload to 0xFFFC does not set it.
- R9: The flags output has four bits:
  - bit 0: compare-1 match.
  - bit 1: compare-2 reload (continuous mode only).
  - bit 2: overflow.
  - bit 3: accepted trigger.
  A flag stays set until a one on the same bit of flag_clr clears it. If an event and a clear arrive in the same cycle, the flag stays set.
- R10: cmp1 and cmp2 are sampled only at the start of a period, so a value written mid-period takes effect from the next period.
- R11: When en is low, the next clock edge puts the state in STOP, the counter at 0xFFFC and the output at lvl_idle, and it restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| mode | input | 1 | 0 continuous, 1 single-shot |
| clk_sel | input | 1 | 0 prescaled system clock, 1 external clock pin |
| presc | input | 8 | Prescaler divide value minus one |
| ext_clk | input | 1 | External tick clock (asynchronous) |
| trig | input | 1 | Trigger pin (asynchronous) |
| trig_rise | input | 1 | 1 rising-edge trigger, 0 falling-edge trigger |
| lvl_pulse | input | 1 | Output level during the pulse |
| lvl_idle | input | 1 | Output level outside the pulse |
| cmp1 | input | 16 | Pulse-end compare value |
| cmp2 | input | 16 | Period-end compare value |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| wave_out | output | 1 | Waveform output |
| cnt_out | output | 16 | Current counter value |
| flags | output | 4 | Sticky event flags |

## Verification
A state register stuck in AFTER or WAIT shows up on wave_out as a missing pulse one tick later. A wrong compare shadow shows up as a pulse edge that lands one or more ticks away from the expected edge within the same period. A wrong reload value shifts every later edge by a fixed number of ticks, and cnt_out exposes it at the first cycle of the period. Prescaler or synchronizer faults show on cnt_out as soon as the first expected tick edge passes.

// File: rtl/pwmgen_pkg.sv
`timescale 1ns/1ps
package pwmgen_pkg;
    localparam int FLAG_N  = 4;
    localparam int F_CMP1  = 0;
    localparam int F_CMP2  = 1;
    localparam int F_OVF   = 2;
    localparam int F_TRIG  = 3;

    typedef enum logic {
        MODE_CONT    = 1'b0,
        MODE_ONESHOT = 1'b1
    } pg_mode_e;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_AFTER = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pwmgen_sync.sv
`timescale 1ns/1ps
module pwmgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic prev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[TOP];
    end

    assign level = chain[TOP];
    assign prev  = prev_q;
endmodule

// File: rtl/pwmgen_tick.sv
`timescale 1ns/1ps
module pwmgen_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             use_ext,
    input  logic [PRE_W-1:0] presc,
    input  logic             ext_rise,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic             pre_hit;

    assign pre_hit = (pcnt == presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pcnt <= '0;
        else if (!en || use_ext)    pcnt <= '0;
        else if (pre_hit)           pcnt <= '0;
        else                        pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        if (!en)          tick = 1'b0;
        else if (use_ext) tick = ext_rise;
        else              tick = pre_hit;
    end

    // R6: with a non-zero divider two ticks never fall on adjacent edges
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !use_ext && presc != '0 && tick) |=> (!tick || presc == '0));
endmodule

// File: rtl/pwmgen_core.sv
`timescale 1ns/1ps
module pwmgen_core
    import pwmgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode,
    input  logic             tick,
    input  logic             trig_edge,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    output logic [CNT_W-1:0] cnt,
    output logic             pulse_on,
    output logic             ev_cmp1,
    output logic             ev_cmp2,
    output logic             ev_ovf,
    output logic             ev_trig
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RELOAD  = CNT_MAX - 3;

    pg_mode_e           md;
    pg_state_e          st, st_n;
    logic [CNT_W-1:0]   cnt_n, sh1, sh1_n, sh2, sh2_n;
    logic               cont;

    assign md   = pg_mode_e'(mode);
    assign cont = (md == MODE_CONT);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_STOP;
            cnt <= RELOAD;
            sh1 <= '0;
            sh2 <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sh1 <= sh1_n;
            sh2 <= sh2_n;
        end
    end

    // next-state and event logic
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        sh1_n   = sh1;
        sh2_n   = sh2;
        ev_cmp1 = 1'b0;
        ev_cmp2 = 1'b0;
        ev_ovf  = 1'b0;
        ev_trig = 1'b0;
        if (!en) begin
            st_n  = ST_STOP;
            cnt_n = RELOAD;
        end else begin
            unique case (st)
                ST_STOP: begin
                    cnt_n = RELOAD;
                    sh1_n = cmp1;
                    sh2_n = cmp2;
                    st_n  = cont ? ST_PULSE : ST_WAIT;
                end
                ST_WAIT: begin
                    cnt_n = RELOAD;
                    if (cont) begin
                        st_n  = ST_PULSE;
                        sh1_n = cmp1;
                        sh2_n = cmp2;
                    end else if (trig_edge) begin
                        st_n    = ST_PULSE;
                        sh1_n   = cmp1;
                        sh2_n   = cmp2;
                        ev_trig = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tick) begin
                        if (cont && cnt == sh2) begin
                            ev_cmp2 = 1'b1;
                            cnt_n   = RELOAD;
                            sh1_n   = cmp1;
                            sh2_n   = cmp2;
                        end else if (cnt == sh1) begin
                            ev_cmp1 = 1'b1;
                            if (cont) begin
                                st_n   = ST_AFTER;
                                cnt_n  = cnt + 1'b1;
                                ev_ovf = (cnt == CNT_MAX);
                            end else begin
                                st_n  = ST_WAIT;
                                cnt_n = RELOAD;
                            end
                        end else begin
                            cnt_n  = cnt + 1'b1;
                            ev_ovf = (cnt == CNT_MAX);
                        end
                    end
                end
                ST_AFTER: begin
                    if (!cont) begin
                        st_n  = ST_WAIT;
                        cnt_n = RELOAD;
                    end else if (tick) begin
                        if (cnt == sh2) begin
                            ev_cmp2 = 1'b1;
                            st_n    = ST_PULSE;
                            cnt_n   = RELOAD;
                            sh1_n   = cmp1;
                            sh2_n   = cmp2;
                        end else begin
                            cnt_n  = cnt + 1'b1;
                            ev_ovf = (cnt == CNT_MAX);
                        end
                    end
                end
                default: begin
                    st_n  = ST_STOP;
                    cnt_n = RELOAD;
                end
            endcase
        end
    end

    // output process
    always_comb begin
        pulse_on = (st == ST_PULSE);
    end

    // R11: a low enable parks the machine at the reload value
    a_r11_disable_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (st == ST_STOP && cnt == RELOAD));

    // R4: while waiting without a trigger the counter does not move
    a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cont && st == ST_WAIT && !trig_edge) |=> (st == ST_WAIT && cnt == RELOAD));

    // R5: a pulse only ends on a tick, never because of a trigger
    a_r5_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_PULSE && !tick && $stable(mode)) |=> (st == ST_PULSE && $stable(cnt)));

    // R2: the period-end match restarts the pulse from the reload value
    a_r2_reload_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cont && tick && (st == ST_PULSE || st == ST_AFTER) && cnt == sh2)
        |=> (st == ST_PULSE && cnt == RELOAD));
endmodule

// File: rtl/pwmgen_top.sv
`timescale 1ns/1ps
module pwmgen_top
    import pwmgen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mode,
    input  logic              clk_sel,
    input  logic [PRE_W-1:0]  presc,
    input  logic              ext_clk,
    input  logic              trig,
    input  logic              trig_rise,
    input  logic              lvl_pulse,
    input  logic              lvl_idle,
    input  logic [CNT_W-1:0]  cmp1,
    input  logic [CNT_W-1:0]  cmp2,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic              wave_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [FLAG_N-1:0] flags
);
    logic              t_lvl, t_prev, e_lvl, e_prev;
    logic              trig_edge, ext_rise, tick, pulse_on;
    logic              ev_cmp1, ev_cmp2, ev_ovf, ev_trig;
    logic [FLAG_N-1:0] ev_vec, flags_q;

    pwmgen_sync #(.STAGES(SYNC_N)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .din(trig), .level(t_lvl), .prev(t_prev)
    );

    pwmgen_sync #(.STAGES(SYNC_N)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .level(e_lvl), .prev(e_prev)
    );

    assign trig_edge = trig_rise ? (t_lvl & ~t_prev) : (~t_lvl & t_prev);
    assign ext_rise  = e_lvl & ~e_prev;

    pwmgen_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .use_ext(clk_sel),
        .presc(presc), .ext_rise(ext_rise), .tick(tick)
    );

    pwmgen_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .tick(tick),
        .trig_edge(trig_edge), .cmp1(cmp1), .cmp2(cmp2), .cnt(cnt_out),
        .pulse_on(pulse_on), .ev_cmp1(ev_cmp1), .ev_cmp2(ev_cmp2),
        .ev_ovf(ev_ovf), .ev_trig(ev_trig)
    );

    always_comb begin
        ev_vec         = '0;
        ev_vec[F_CMP1] = ev_cmp1;
        ev_vec[F_CMP2] = ev_cmp2;
        ev_vec[F_OVF]  = ev_ovf;
        ev_vec[F_TRIG] = ev_trig;
    end

    generate
        for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags_q[i] <= 1'b0;
                else        flags_q[i] <= ev_vec[i] | (flags_q[i] & ~flag_clr[i]);
            end
        end
    endgenerate

    assign flags    = flags_q;
    assign wave_out = pulse_on ? lvl_pulse : lvl_idle;

    // R9: a set flag only falls where a clear was written
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_q) |=> ((($past(flags_q) & ~$past(flag_clr)) & ~flags_q) == '0));

    // R9: an event beats a simultaneous clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vec) |=> ((flags_q & $past(ev_vec)) == $past(ev_vec)));

    // R7: one synchronized external rising edge yields a single-cycle tick source
    a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: tb/pwmgen_top_test.sv
`timescale 1ns/1ps
module pwmgen_top_test;
    logic        clk = 1'b0;
    logic        rst_n, en, mode, clk_sel, ext_clk, trig, trig_rise;
    logic        lvl_pulse, lvl_idle, wave_out;
    logic [7:0]  presc;
    logic [15:0] cmp1, cmp2, cnt_out;
    logic [3:0]  flag_clr, flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwmgen_top uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .clk_sel(clk_sel),
        .presc(presc), .ext_clk(ext_clk), .trig(trig), .trig_rise(trig_rise),
        .lvl_pulse(lvl_pulse), .lvl_idle(lvl_idle), .cmp1(cmp1), .cmp2(cmp2),
        .flag_clr(flag_clr), .wave_out(wave_out), .cnt_out(cnt_out), .flags(flags)
    );

    // {cmp1, cmp2, lvl_pulse, lvl_idle}
    localparam logic [33:0] VEC [0:4] = '{
        {16'h0003, 16'h000A, 1'b1, 1'b0},
        {16'h0000, 16'h0005, 1'b0, 1'b1},
        {16'hFFFD, 16'h0002, 1'b1, 1'b0},
        {16'h0008, 16'h0004, 1'b1, 1'b0},
        {16'hFFFC, 16'hFFFE, 1'b1, 1'b0}
    };

    task automatic steps(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic restart_disabled();
        en = 1'b0;
        steps(1);
        flag_clr = 4'hF;
        steps(1);
        flag_clr = 4'h0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = 1'b0; clk_sel = 1'b0; presc = 8'd0;
        ext_clk = 1'b0; trig = 1'b0; trig_rise = 1'b1; lvl_pulse = 1'b1;
        lvl_idle = 1'b0; cmp1 = 16'h0003; cmp2 = 16'h000A; flag_clr = 4'h0;
        steps(3);
        chk("R1 reset wave", {15'd0, wave_out}, 16'd0);
        chk("R1 reset flags", {12'd0, flags}, 16'd0);
        chk("R1 reset count", cnt_out, 16'hFFFC);
        rst_n = 1'b1;
        steps(2);
        chk("R1 idle after reset count", cnt_out, 16'hFFFC);

        // R2 / R3: vector walk in continuous mode, presc 0
        for (int v = 0; v < 5; v++) begin
            restart_disabled();
            cmp1 = VEC[v][33:18]; cmp2 = VEC[v][17:2];
            lvl_pulse = VEC[v][1]; lvl_idle = VEC[v][0];
            begin
                int w;
                int p;
                w = int'(16'(cmp1 + 16'd4)) + 1;
                p = int'(16'(cmp2 + 16'd4)) + 1;
                en = 1'b1;
                steps(1);
                chk("R2 period start count", cnt_out, 16'hFFFC);
                for (int k = 0; k < 2 * p; k++) begin
                    logic e;
                    e = ((k % p) < w) ? lvl_pulse : lvl_idle;
                    chk((w >= p) ? "R3 reload priority wave" : "R2 pwm wave",
                        {15'd0, wave_out}, {15'd0, e});
                    steps(1);
                end
            end
        end

        // R10: compare change mid-period applies next period
        restart_disabled();
        cmp1 = 16'h0003; cmp2 = 16'h000A; lvl_pulse = 1'b1; lvl_idle = 1'b0;
        en = 1'b1;
        steps(1);
        steps(2);
        cmp1 = 16'h0000;
        steps(4);
        chk("R10 old width kept E6", {15'd0, wave_out}, 16'd1);
        steps(1);
        chk("R10 old width kept E7", {15'd0, wave_out}, 16'd1);
        steps(1);
        chk("R10 old width ends E8", {15'd0, wave_out}, 16'd0);
        steps(11);
        chk("R10 new width E19", {15'd0, wave_out}, 16'd1);
        steps(1);
        chk("R10 new width ends E20", {15'd0, wave_out}, 16'd0);

        // R9 / R8: flags, clear racing an event
        restart_disabled();
        chk("R9 cleared", {12'd0, flags}, 16'd0);
        cmp1 = 16'hFFFC; cmp2 = 16'hFFFE;
        en = 1'b1;
        steps(1);
        steps(2);
        flag_clr = 4'b0010;
        steps(1);
        chk("R9 event beats clear", {15'd0, flags[1]}, 16'd1);
        flag_clr = 4'b0010;
        steps(1);
        flag_clr = 4'b0000;
        chk("R9 clear and sticky bits, R8 no overflow", {12'd0, flags}, 16'h0001);

        // R4 / R5: single-shot, rising trigger
        restart_disabled();
        mode = 1'b1; cmp1 = 16'h0002; trig = 1'b0; trig_rise = 1'b1;
        en = 1'b1;
        steps(1);
        steps(5);
        chk("R4 wait holds count", cnt_out, 16'hFFFC);
        chk("R4 wait idle", {15'd0, wave_out}, 16'd0);
        trig = 1'b1;
        steps(2);
        chk("R4 not yet started T2", {15'd0, wave_out}, 16'd0);
        steps(1);
        chk("R4 pulse starts T3", {15'd0, wave_out}, 16'd1);
        chk("R9 trigger flag", {15'd0, flags[3]}, 16'd1);
        steps(1);
        trig = 1'b0;
        steps(2);
        trig = 1'b1;
        steps(3);
        chk("R5 pulse not disturbed T9", {15'd0, wave_out}, 16'd1);
        steps(1);
        chk("R4 pulse ends T10", {15'd0, wave_out}, 16'd0);
        chk("R4 count back at reload", cnt_out, 16'hFFFC);
        chk("R9 cmp1 flag in single-shot", {15'd0, flags[0]}, 16'd1);
        steps(6);
        chk("R5 no retrigger", {15'd0, wave_out}, 16'd0);
        // falling polarity
        trig_rise = 1'b0;
        steps(1);
        trig = 1'b0;
        steps(2);
        chk("R4 falling not yet", {15'd0, wave_out}, 16'd0);
        steps(1);
        chk("R4 falling starts pulse", {15'd0, wave_out}, 16'd1);

        // R6: prescaler divide by 4
        restart_disabled();
        mode = 1'b0; presc = 8'd3; cmp1 = 16'h0000; cmp2 = 16'h0002;
        en = 1'b1;
        steps(1);
        steps(6);
        chk("R6 count after E6", cnt_out, 16'hFFFD);
        steps(1);
        chk("R6 count after E7", cnt_out, 16'hFFFE);
        steps(11);
        chk("R6 pulse at E18", {15'd0, wave_out}, 16'd1);
        steps(1);
        chk("R6 pulse ends E19", {15'd0, wave_out}, 16'd0);
        chk("R8 overflow passed", {15'd0, flags[2]}, 16'd1);

        // R7 / R8: external clock, prescaler ignored
        restart_disabled();
        clk_sel = 1'b1; presc = 8'd3; cmp1 = 16'h0100; cmp2 = 16'h0200;
        ext_clk = 1'b0;
        en = 1'b1;
        steps(1);
        steps(8);
        chk("R7 no ext edge no count", cnt_out, 16'hFFFC);
        repeat (5) begin
            ext_clk = 1'b1;
            steps(4);
            ext_clk = 1'b0;
            steps(4);
        end
        steps(4);
        chk("R7 five ext edges", cnt_out, 16'h0001);
        chk("R8 overflow flag ext", {15'd0, flags[2]}, 16'd1);
        chk("R7 still in pulse", {15'd0, wave_out}, 16'd1);

        // R11: disable
        en = 1'b0;
        steps(1);
        chk("R11 disable wave", {15'd0, wave_out}, 16'd0);
        chk("R11 disable count", cnt_out, 16'hFFFC);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule